// File: doc/BRIEF.md
# Program/Erase Suspend Arbiter

This block supervises an embedded program/erase engine in a block-erasable non-volatile memory. It tracks whether a program or an erase is running, suspended, or running a program nested inside a suspended erase. For every host request (read, program, erase) it decides in the same cycle whether the request may start or must be refused. The decision depends on the current state and on whether the request targets the block whose operation is on hold.

The timing engine reports the end of an operation with a one-cycle `eng_done` or `eng_fail` pulse. A failure raises a sticky error flag that stays set until the host issues a clear. Suspension works on two levels:

- An erase on hold admits reads and programs to any other block.
- A program on hold admits only reads to other blocks.
- A program started while an erase is on hold must finish before the erase can resume. A resume that arrives too early is remembered until then.

The states are:

- `ST_IDLE`: no operation.
- `ST_PGM_RUN`: program running.
- `ST_ERS_RUN`: erase running.
- `ST_PGM_HOLD`: program suspended.
- `ST_ERS_HOLD`: erase suspended.
- `ST_ERS_HOLD_PGM`: program running while an erase is suspended.

The transitions are:

- start-program: `ST_IDLE` to `ST_PGM_RUN`, or `ST_ERS_HOLD` to `ST_ERS_HOLD_PGM`.
- start-erase: `ST_IDLE` to `ST_ERS_RUN`.
- suspend: `ST_PGM_RUN` to `ST_PGM_HOLD`, and `ST_ERS_RUN` to `ST_ERS_HOLD`.
- resume: `ST_PGM_HOLD` to `ST_PGM_RUN`, and `ST_ERS_HOLD` to `ST_ERS_RUN`.
- finish: each RUN state to `ST_IDLE`.
- nested-finish: `ST_ERS_HOLD_PGM` to `ST_ERS_HOLD`, or to `ST_ERS_RUN` when a resume is pending.

Top module: `pesa_top`

## Requirements
- R1: After reset `ready`=1, `suspended`=0, `err_flag`=0, and all accept flags are 0.
- R2: In `ST_IDLE` a read to any block is accepted. A program request is accepted and starts a program. An erase request is accepted and starts an erase only when no program is requested in the same cycle. After a start, `ready` is 0 from the next cycle.
- R3: While a program or an erase is running (`ready`=0), every read, program and erase request is rejected. Each reject flag equals its request.
- R4: A suspend in `ST_PGM_RUN` or `ST_ERS_RUN` without a done/fail pulse gives `suspended`=1 and `ready`=1 in the next cycle.
- R5: With an erase suspended, reads and programs to a block index different from the erasing block are accepted. Those to the erasing block are rejected. An accepted program runs nested (`ready`=0, `suspended`=1).
- R6: With a program suspended, only reads to a block different from the programming block are accepted. Program and erase requests are rejected.
- R7: An erase request is rejected in every state other than `ST_IDLE`.
- R8: A resume returns a suspended operation to running (`ready`=0, `suspended`=0). Its next done pulse returns the block to `ST_IDLE`.
- R9: A resume received during a nested program, or in the cycle it ends, is held. When the nested program ends the erase resumes. Without a resume it returns to the erase-suspended state. A suspend during a nested program is ignored.
- R10: A fail pulse during a running operation ends it and sets `err_flag`. `err_flag` stays 1 until `clr_status`. A fail and a clear in the same cycle leave it set.
- R11: Suspend, resume, done and fail are ignored in `ST_IDLE`. Done and fail are also ignored while an operation is suspended.
- R12: A done pulse arriving together with a suspend ends the operation (`ST_IDLE`) rather than suspending it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_read | input | 1 | Host read request |
| req_prog | input | 1 | Host program request |
| req_erase | input | 1 | Host erase request |
| req_blk | input | BLK_W | Target block index of the request |
| cmd_suspend | input | 1 | Suspend command |
| cmd_resume | input | 1 | Resume command |
| clr_status | input | 1 | Clear the error flag |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Engine failure pulse |
| ready | output | 1 | Engine not busy |
| suspended | output | 1 | An operation is on hold |
| err_flag | output | 1 | Sticky failure flag |
| read_ok | output | 1 | Read accepted |
| read_rej | output | 1 | Read refused |
| prog_ok | output | 1 | Program accepted |
| prog_rej | output | 1 | Program refused |
| erase_ok | output | 1 | Erase accepted |
| erase_rej | output | 1 | Erase refused |

## Verification
The bench builds the block with `BLK_W` = 4. This puts both ends of the index range, block 0 and block 15, within a few cycles, so the same-block and other-block comparisons are exercised at the edges of the index space. The small width lets the bench walk every state and every held-resume ordering with short, directed sequences. A behavioural model predicts all outputs on every clock.

// File: rtl/pesa_pkg.sv
package pesa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM_RUN,
        ST_ERS_RUN,
        ST_PGM_HOLD,
        ST_ERS_HOLD,
        ST_ERS_HOLD_PGM
    } pesa_state_e;
endpackage

// File: rtl/pesa_gate.sv
module pesa_gate
    import pesa_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input  pesa_state_e      state_i,
    input  logic             req_read_i,
    input  logic             req_prog_i,
    input  logic             req_erase_i,
    input  logic [BLK_W-1:0] req_blk_i,
    input  logic [BLK_W-1:0] pgm_blk_i,
    input  logic [BLK_W-1:0] ers_blk_i,
    output logic             read_ok_o,
    output logic             prog_ok_o,
    output logic             erase_ok_o
);
    logic hits_pgm;
    logic hits_ers;

    assign hits_pgm = (req_blk_i == pgm_blk_i);
    assign hits_ers = (req_blk_i == ers_blk_i);

    always_comb begin
        read_ok_o  = 1'b0;
        prog_ok_o  = 1'b0;
        erase_ok_o = 1'b0;
        unique case (state_i)
            ST_IDLE: begin
                read_ok_o  = req_read_i;
                prog_ok_o  = req_prog_i;
                erase_ok_o = req_erase_i && !req_prog_i;
            end
            ST_PGM_HOLD: begin
                read_ok_o = req_read_i && !hits_pgm;
            end
            ST_ERS_HOLD: begin
                read_ok_o = req_read_i && !hits_ers;
                prog_ok_o = req_prog_i && !hits_ers;
            end
            default: begin
                read_ok_o  = 1'b0;
                prog_ok_o  = 1'b0;
                erase_ok_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pesa_fsm.sv
module pesa_fsm
    import pesa_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_go_i,
    input  logic             erase_go_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic             suspend_i,
    input  logic             resume_i,
    input  logic             done_i,
    input  logic             fail_i,
    output pesa_state_e      state_o,
    output logic [BLK_W-1:0] pgm_blk_o,
    output logic [BLK_W-1:0] ers_blk_o,
    output logic             ready_o,
    output logic             susp_o
);
    pesa_state_e      state_q, state_d;
    logic             pend_q, pend_d;
    logic [BLK_W-1:0] pgm_blk_q, ers_blk_q;
    logic             end_op;

    assign end_op = done_i || fail_i;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (prog_go_i)       state_d = ST_PGM_RUN;
                else if (erase_go_i) state_d = ST_ERS_RUN;
            end
            ST_PGM_RUN: begin
                if (end_op)         state_d = ST_IDLE;
                else if (suspend_i) state_d = ST_PGM_HOLD;
            end
            ST_ERS_RUN: begin
                if (end_op)         state_d = ST_IDLE;
                else if (suspend_i) state_d = ST_ERS_HOLD;
            end
            ST_PGM_HOLD: begin
                if (resume_i) state_d = ST_PGM_RUN;
            end
            ST_ERS_HOLD: begin
                if (prog_go_i) begin
                    state_d = ST_ERS_HOLD_PGM;
                    pend_d  = resume_i;
                end else if (resume_i) begin
                    state_d = ST_ERS_RUN;
                end
            end
            ST_ERS_HOLD_PGM: begin
                if (end_op) begin
                    state_d = (pend_q || resume_i) ? ST_ERS_RUN : ST_ERS_HOLD;
                    pend_d  = 1'b0;
                end else if (resume_i) begin
                    pend_d = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                pend_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pend_q    <= 1'b0;
            pgm_blk_q <= '0;
            ers_blk_q <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (prog_go_i)  pgm_blk_q <= blk_i;
            if (erase_go_i) ers_blk_q <= blk_i;
        end
    end

    always_comb begin
        ready_o = 1'b0;
        susp_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:         ready_o = 1'b1;
            ST_PGM_HOLD,
            ST_ERS_HOLD: begin
                ready_o = 1'b1;
                susp_o  = 1'b1;
            end
            ST_ERS_HOLD_PGM: susp_o = 1'b1;
            default: begin
                ready_o = 1'b0;
                susp_o  = 1'b0;
            end
        endcase
    end

    assign state_o   = state_q;
    assign pgm_blk_o = pgm_blk_q;
    assign ers_blk_o = ers_blk_q;

    p_susp_pgm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PGM_RUN && suspend_i && !end_op) |=> (state_q == ST_PGM_HOLD));
    p_susp_ers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERS_RUN && suspend_i && !end_op) |=> (state_q == ST_ERS_HOLD));
    p_erase_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go_i |=> (state_q == ST_ERS_RUN));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !prog_go_i && !erase_go_i) |=> (state_q == ST_IDLE));
    p_done_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PGM_RUN || state_q == ST_ERS_RUN) && done_i) |=> (state_q == ST_IDLE));
    p_nested_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERS_HOLD_PGM && !end_op) |=> (state_q == ST_ERS_HOLD_PGM));
endmodule

// File: rtl/pesa_errflag.sv
module pesa_errflag
    import pesa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  pesa_state_e state_i,
    input  logic        fail_i,
    input  logic        clear_i,
    output logic        err_o
);
    logic err_q;
    logic running;

    assign running = (state_i == ST_PGM_RUN) || (state_i == ST_ERS_RUN) ||
                     (state_i == ST_ERS_HOLD_PGM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 err_q <= 1'b0;
        else if (fail_i && running) err_q <= 1'b1;
        else if (clear_i)           err_q <= 1'b0;
    end

    assign err_o = err_q;

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clear_i) |=> err_q);
    p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && running) |=> err_q);
endmodule

// File: rtl/pesa_top.sv
module pesa_top
    import pesa_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_read,
    input  logic             req_prog,
    input  logic             req_erase,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             cmd_suspend,
    input  logic             cmd_resume,
    input  logic             clr_status,
    input  logic             eng_done,
    input  logic             eng_fail,
    output logic             ready,
    output logic             suspended,
    output logic             err_flag,
    output logic             read_ok,
    output logic             read_rej,
    output logic             prog_ok,
    output logic             prog_rej,
    output logic             erase_ok,
    output logic             erase_rej
);
    pesa_state_e      state;
    logic [BLK_W-1:0] pgm_blk;
    logic [BLK_W-1:0] ers_blk;

    pesa_gate #(.BLK_W(BLK_W)) gate_i (
        .state_i    (state),
        .req_read_i (req_read),
        .req_prog_i (req_prog),
        .req_erase_i(req_erase),
        .req_blk_i  (req_blk),
        .pgm_blk_i  (pgm_blk),
        .ers_blk_i  (ers_blk),
        .read_ok_o  (read_ok),
        .prog_ok_o  (prog_ok),
        .erase_ok_o (erase_ok)
    );

    pesa_fsm #(.BLK_W(BLK_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_go_i (prog_ok),
        .erase_go_i(erase_ok),
        .blk_i     (req_blk),
        .suspend_i (cmd_suspend),
        .resume_i  (cmd_resume),
        .done_i    (eng_done),
        .fail_i    (eng_fail),
        .state_o   (state),
        .pgm_blk_o (pgm_blk),
        .ers_blk_o (ers_blk),
        .ready_o   (ready),
        .susp_o    (suspended)
    );

    pesa_errflag err_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .state_i(state),
        .fail_i (eng_fail),
        .clear_i(clr_status),
        .err_o  (err_flag)
    );

    assign read_rej  = req_read  && !read_ok;
    assign prog_rej  = req_prog  && !prog_ok;
    assign erase_rej = req_erase && !erase_ok;

    p_busy_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!read_ok && !prog_ok && !erase_ok));
    p_erase_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_ok |-> (ready && !suspended));
    p_ers_hold_blk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERS_HOLD && (read_ok || prog_ok)) |-> (req_blk != ers_blk));
    p_pgm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PGM_HOLD) |-> (!prog_ok && !erase_ok && (!read_ok || req_blk != pgm_blk)));
endmodule

// File: tb/pesa_top_tb_top.sv
`timescale 1ns/1ps
module pesa_top_tb_top;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic r_rd = 0, r_pg = 0, r_er = 0, c_su = 0, c_re = 0, c_cl = 0, e_dn = 0, e_fl = 0;
    logic [BW-1:0] r_blk = '0;
    logic ready, suspended, err_flag, read_ok, read_rej, prog_ok, prog_rej, erase_ok, erase_rej;

    int checks = 0;
    int fails = 0;

    // behavioural model: 0 idle,1 prog run,2 erase run,3 prog hold,4 erase hold,5 nested prog
    int m_st = 0, m_pb = 0, m_eb = 0;
    bit m_pend = 0, m_err = 0;

    always #4 clk = ~clk;

    pesa_top #(.BLK_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_read(r_rd), .req_prog(r_pg), .req_erase(r_er),
        .req_blk(r_blk), .cmd_suspend(c_su), .cmd_resume(c_re), .clr_status(c_cl),
        .eng_done(e_dn), .eng_fail(e_fl), .ready(ready), .suspended(suspended),
        .err_flag(err_flag), .read_ok(read_ok), .read_rej(read_rej), .prog_ok(prog_ok),
        .prog_rej(prog_rej), .erase_ok(erase_ok), .erase_rej(erase_rej)
    );

    function automatic logic [8:0] expect_vec(bit rd, bit pg, bit er, int blk);
        bit rok, pok, eok, rdy, sus;
        rok = rd && ((m_st == 0) || (m_st == 3 && blk != m_pb) || (m_st == 4 && blk != m_eb));
        pok = pg && ((m_st == 0) || (m_st == 4 && blk != m_eb));
        eok = er && m_st == 0 && !pg;
        rdy = (m_st == 0 || m_st == 3 || m_st == 4);
        sus = (m_st >= 3);
        return {rdy, sus, m_err, rok, rd && !rok, pok, pg && !pok, eok, er && !eok};
    endfunction

    task automatic apply(input string tag, input bit rd, input bit pg, input bit er, input int blk,
                         input bit su, input bit re, input bit cl, input bit dn, input bit fl);
        logic [8:0] got, exp;
        bit pok, eok, busy;
        @(negedge clk);
        r_rd = rd; r_pg = pg; r_er = er; r_blk = BW'(blk);
        c_su = su; c_re = re; c_cl = cl; e_dn = dn; e_fl = fl;
        #2;
        exp = expect_vec(rd, pg, er, blk);
        got = {ready, suspended, err_flag, read_ok, read_rej, prog_ok, prog_rej, erase_ok, erase_rej};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: outputs got %b expected %b (state %0d)", tag, got, exp, m_st);
        end
        @(posedge clk);
        pok = exp[3];
        eok = exp[1];
        busy = (m_st == 1 || m_st == 2 || m_st == 5);
        if (fl && busy) m_err = 1;
        else if (cl) m_err = 0;
        case (m_st)
            0: if (pok) begin m_st = 1; m_pb = blk; end
               else if (eok) begin m_st = 2; m_eb = blk; end
            1: if (dn || fl) m_st = 0; else if (su) m_st = 3;
            2: if (dn || fl) m_st = 0; else if (su) m_st = 4;
            3: if (re) m_st = 1;
            4: if (pok) begin m_st = 5; m_pb = blk; m_pend = re; end
               else if (re) m_st = 2;
            5: if (dn || fl) begin m_st = (m_pend || re) ? 2 : 4; m_pend = 0; end
               else if (re) m_pend = 1;
            default: m_st = 0;
        endcase
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) apply(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({ready, suspended, err_flag, read_ok, prog_ok, erase_ok} !== 6'b100000) begin
            fails++;
            $display("FAIL R1: reset outputs got %b expected 100000",
                     {ready, suspended, err_flag, read_ok, prog_ok, erase_ok});
        end
        rst_n = 1'b1;
        idle("R1", 1);
        // R2 idle reads, program priority over erase
        apply("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R2", 1, 0, 0, 15, 0, 0, 0, 0, 0);
        apply("R2", 0, 1, 1, 5, 0, 0, 0, 0, 0);
        // R3 everything refused while running
        apply("R3", 1, 0, 0, 1, 0, 0, 0, 0, 0);
        apply("R3", 0, 1, 0, 2, 0, 0, 0, 0, 0);
        apply("R7", 0, 0, 1, 3, 0, 0, 0, 0, 0);
        apply("R2", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R11 idle ignores commands and engine pulses
        apply("R11", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        apply("R11", 0, 0, 0, 0, 0, 1, 0, 1, 0);
        apply("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        idle("R11", 1);
        // R4 / R6 program suspend
        apply("R2", 0, 1, 0, 15, 0, 0, 0, 0, 0);
        apply("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        apply("R6", 1, 0, 0, 15, 0, 0, 0, 0, 0);
        apply("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R6", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        apply("R7", 0, 0, 1, 0, 0, 0, 0, 0, 0);
        apply("R11", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        apply("R8", 0, 0, 0, 0, 0, 1, 0, 0, 0);
        apply("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R8", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        idle("R8", 1);
        // R5 / R9 erase suspend with nested program and early resume
        apply("R2", 0, 0, 1, 0, 0, 0, 0, 0, 0);
        apply("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        apply("R5", 1, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R5", 1, 0, 0, 15, 0, 0, 0, 0, 0);
        apply("R5", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        apply("R7", 0, 0, 1, 9, 0, 0, 0, 0, 0);
        apply("R5", 1, 1, 0, 9, 0, 0, 0, 0, 0);
        apply("R9", 1, 0, 0, 3, 1, 1, 0, 0, 0);
        apply("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R9", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        apply("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R8", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        idle("R8", 1);
        // R9 nested program without resume, then resume in the ending cycle
        apply("R2", 0, 0, 1, 7, 0, 0, 0, 0, 0);
        apply("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        apply("R5", 0, 1, 0, 6, 0, 0, 0, 0, 0);
        apply("R9", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        apply("R9", 0, 1, 0, 8, 0, 0, 0, 0, 0);
        apply("R9", 0, 0, 0, 0, 0, 1, 0, 1, 0);
        // R10 failure ends the resumed erase, flag sticky
        apply("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        apply("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R10", 0, 1, 0, 4, 0, 0, 0, 0, 0);
        apply("R10", 0, 0, 0, 0, 0, 0, 1, 0, 1);
        apply("R10", 0, 0, 0, 0, 0, 0, 1, 0, 0);
        idle("R10", 2);
        // R12 done beats suspend
        apply("R12", 0, 1, 0, 2, 0, 0, 0, 0, 0);
        apply("R12", 0, 0, 0, 0, 1, 0, 0, 1, 0);
        apply("R12", 0, 0, 1, 2, 0, 0, 0, 0, 0);
        apply("R12", 0, 0, 0, 0, 1, 0, 0, 1, 0);
        idle("R12", 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule